// File: doc/BRIEF.md
# Retirement PC Continuity Checker

This block watches instructions as they retire and confirms that they leave the machine in program order. It holds one register, the retirement PC, which is the address the next retiring instruction must have. Each retiring instruction brings its own PC, the length in bytes that decode recorded for it, a taken flag and its resolved target. The checker compares the PC with the retirement PC. It then advances the retirement PC by the length, or loads the target when the taken flag is set.

Any mismatch, or any retiring instruction whose length is zero, is a control-flow discontinuity. This one comparison catches several faults: a wrong PC from the front end, instructions that were dropped or inserted, instructions retired out of order, and allocation into the wrong reorder-buffer slot. When a discontinuity is found, the block raises a one-cycle flush request and records the error. It then waits for the flush, which reloads the retirement PC from the restart address. Up to two instructions retire per cycle, in slot order. The younger slot is checked against the address that results from the older slot in the same cycle.

Top module: `retire_pc_checker`

## Requirements
- R1: While `rst_n` is low at a clock edge, the retirement PC becomes `RESET_PC` (default 0x1000), and `err_o` and `flush_req_o` become 0.
- R2: A valid slot-0 commit whose PC differs from the retirement PC sets `err_o` on the next cycle. In that case `err_slot_o` = 0, `err_exp_pc_o` holds the retirement PC and `err_obs_pc_o` holds the committed PC.
- R3: A matching commit whose taken flag is 0 advances the retirement PC by its 4-bit length. This holds for sequential instructions and for not-taken branches alike; the target input is ignored.
- R4: A matching commit whose taken flag is 1 loads the retirement PC with its target input.
- R5: When both slots are valid, slot 1 is compared against the PC that results from slot 0 in the same cycle, and the retirement PC ends at the result after slot 1.
- R6: A valid commit with length 0 is an error, even if its PC matches.
- R7: When `flush_i` is high, the retirement PC is loaded from `restart_pc_i` and no commit in that cycle is checked.
- R8: `flush_req_o` is high for exactly the one cycle after each cycle in which a discontinuity was detected.
- R9: The error record (slot, expected and observed PC) is held and not overwritten by later errors until `err_clr_i` is high. A clear with no new error in that cycle drops `err_o`. A new error in the same cycle as a clear is recorded.
- R10: In a cycle with a detected error the retirement PC does not change, and slots younger than the failing slot are not checked.
- R11: A valid slot 1 with slot 0 idle is checked against the retirement PC directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Pipeline flush; resynchronises the checker |
| restart_pc_i | input | 32 | Address execution restarts from |
| commit_vld_i | input | 2 | Per-slot commit valid, bit 0 = oldest |
| commit_pc_i | input | 64 | Per-slot PC, slot k at bits [32k+31:32k] |
| commit_len_i | input | 8 | Per-slot length in bytes, slot k at [4k+3:4k] |
| commit_taken_i | input | 2 | Per-slot taken-branch flag |
| commit_tgt_i | input | 64 | Per-slot resolved branch target |
| err_clr_i | input | 1 | Clears the held error record |
| err_o | output | 1 | An error record is held |
| err_slot_o | output | 1 | Slot of the recorded error |
| err_exp_pc_o | output | 32 | PC expected at the recorded error |
| err_obs_pc_o | output | 32 | PC observed at the recorded error |
| flush_req_o | output | 1 | One-cycle flush request after a detection |
| retire_pc_o | output | 32 | Current retirement PC |

## Verification
Three pairs of events can fall in the same cycle: an error clear and a new detection, a flush and commits, and a slot-1 mismatch behind a good slot 0. The table-driven run provokes each pair. It judges the result by the record shown after the clear, by the retirement PC after the flush, and by the unchanged retirement PC after a chained failure. It also issues a second error while one is held, and checks that the first record survives while a flush request is still raised.

// File: rtl/rpc_pkg.sv
// Shared sizes and helpers for the retirement PC checker.
// Assumes lengths are unsigned byte counts narrower than the PC.
package rpc_pkg;
    localparam int PC_W  = 32;
    localparam int LEN_W = 4;

    // Sequential successor of a PC: add the zero-extended length.
    function automatic logic [PC_W-1:0] seq_next(input logic [PC_W-1:0] pc,
                                                 input logic [LEN_W-1:0] len);
        return pc + {{(PC_W-LEN_W){1'b0}}, len};
    endfunction
endpackage

// File: rtl/rpc_slot.sv
// One commit slot of the continuity check.
// Compares the slot PC with the expected PC handed down from the older slot.
// Passes on the expected PC for the next slot.
// Assumes chk_en is low when an older slot failed or a flush is active.
module rpc_slot
    import rpc_pkg::*;
(
    input  logic             chk_en,
    input  logic             vld,
    input  logic [PC_W-1:0]  pc,
    input  logic [LEN_W-1:0] len,
    input  logic             taken,
    input  logic [PC_W-1:0]  tgt,
    input  logic [PC_W-1:0]  exp_in,
    output logic             bad,
    output logic [PC_W-1:0]  exp_out
);
    logic active;

    // Decide whether this slot is checked, and whether it fails.
    always_comb begin
        active = chk_en && vld;
        bad    = active && ((pc != exp_in) || (len == '0));
    end

    // Next expected PC: the target when taken, else PC plus length; unchanged when idle.
    always_comb begin
        if (!active)
            exp_out = exp_in;
        else if (taken)
            exp_out = tgt;
        else
            exp_out = seq_next(exp_in, len);
    end
endmodule

// File: rtl/rpc_err_rec.sv
// Sticky error record: keeps the first discontinuity until software or a
// controller clears it. A detection in the same cycle as a clear is kept.
module rpc_err_rec
    import rpc_pkg::*;
#(
    parameter int SLOT_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              det,
    input  logic [SLOT_W-1:0] det_slot,
    input  logic [PC_W-1:0]   det_exp,
    input  logic [PC_W-1:0]   det_obs,
    input  logic              clr,
    output logic              err,
    output logic [SLOT_W-1:0] slot,
    output logic [PC_W-1:0]   exp_pc,
    output logic [PC_W-1:0]   obs_pc
);
    // Capture a new error when free or being cleared; otherwise hold or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err    <= 1'b0;
            slot   <= '0;
            exp_pc <= '0;
            obs_pc <= '0;
        end else if (det && (!err || clr)) begin
            err    <= 1'b1;
            slot   <= det_slot;
            exp_pc <= det_exp;
            obs_pc <= det_obs;
        end else if (clr) begin
            err    <= 1'b0;
        end
    end

    // R9: a held record is not disturbed without a clear.
    p_record_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr) |=> (err && $stable(exp_pc) && $stable(obs_pc) && $stable(slot)));
endmodule

// File: rtl/retire_pc_checker.sv
// Retirement PC continuity checker.
// Keeps the retirement PC, checks up to SLOTS commits per cycle in slot order,
// raises a one-cycle flush request on a discontinuity and records the first one.
// Assumes slot 0 is the oldest, and that the flush that follows a request
// delivers the restart PC on flush_i/restart_pc_i.
module retire_pc_checker
    import rpc_pkg::*;
#(
    parameter int              SLOTS    = 2,
    parameter logic [PC_W-1:0] RESET_PC = 32'h0000_1000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush_i,
    input  logic [PC_W-1:0]         restart_pc_i,
    input  logic [SLOTS-1:0]        commit_vld_i,
    input  logic [SLOTS*PC_W-1:0]   commit_pc_i,
    input  logic [SLOTS*LEN_W-1:0]  commit_len_i,
    input  logic [SLOTS-1:0]        commit_taken_i,
    input  logic [SLOTS*PC_W-1:0]   commit_tgt_i,
    input  logic                    err_clr_i,
    output logic                    err_o,
    output logic [((SLOTS>1)?$clog2(SLOTS):1)-1:0] err_slot_o,
    output logic [PC_W-1:0]         err_exp_pc_o,
    output logic [PC_W-1:0]         err_obs_pc_o,
    output logic                    flush_req_o,
    output logic [PC_W-1:0]         retire_pc_o
);
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic [PC_W-1:0] retire_pc_q;
    logic [PC_W-1:0] exp_chain [SLOTS+1];
    logic [SLOTS:0]  en_chain;
    logic [SLOTS-1:0] bad_vec;

    assign exp_chain[0] = retire_pc_q;
    assign en_chain[0]  = !flush_i;

    // One checker per slot, each fed by the result of the older slot.
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        rpc_slot u_slot (
            .chk_en  (en_chain[k]),
            .vld     (commit_vld_i[k]),
            .pc      (commit_pc_i[k*PC_W +: PC_W]),
            .len     (commit_len_i[k*LEN_W +: LEN_W]),
            .taken   (commit_taken_i[k]),
            .tgt     (commit_tgt_i[k*PC_W +: PC_W]),
            .exp_in  (exp_chain[k]),
            .bad     (bad_vec[k]),
            .exp_out (exp_chain[k+1])
        );
        assign en_chain[k+1] = en_chain[k] && !bad_vec[k];
    end

    logic              any_bad;
    logic [SLOT_W-1:0] bad_slot;
    logic [PC_W-1:0]   bad_exp;
    logic [PC_W-1:0]   bad_obs;

    // Pick the failing slot; at most one fails since younger ones are disabled.
    always_comb begin
        any_bad  = |bad_vec;
        bad_slot = '0;
        bad_exp  = '0;
        bad_obs  = '0;
        for (int k = 0; k < SLOTS; k++) begin
            if (bad_vec[k]) begin
                bad_slot = SLOT_W'(k);
                bad_exp  = exp_chain[k];
                bad_obs  = commit_pc_i[k*PC_W +: PC_W];
            end
        end
    end

    // Retirement PC: reload on flush, hold on error, else take the chain result.
    always_ff @(posedge clk) begin
        if (!rst_n)
            retire_pc_q <= RESET_PC;
        else if (flush_i)
            retire_pc_q <= restart_pc_i;
        else if (!any_bad)
            retire_pc_q <= exp_chain[SLOTS];
    end

    // Flush request: one cycle after each detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flush_req_o <= 1'b0;
        else
            flush_req_o <= any_bad;
    end

    rpc_err_rec #(.SLOT_W(SLOT_W)) u_rec (
        .clk      (clk),
        .rst_n    (rst_n),
        .det      (any_bad),
        .det_slot (bad_slot),
        .det_exp  (bad_exp),
        .det_obs  (bad_obs),
        .clr      (err_clr_i),
        .err      (err_o),
        .slot     (err_slot_o),
        .exp_pc   (err_exp_pc_o),
        .obs_pc   (err_obs_pc_o)
    );

    assign retire_pc_o = retire_pc_q;

    // R7: a flush reloads the retirement PC from the restart input.
    p_flush_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (retire_pc_o == $past(restart_pc_i)));

    // R8: every flush request comes with a held error record.
    p_req_has_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req_o |-> err_o);

    // R6: a zero-length commit in slot 0 outside a flush is reported.
    p_zero_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && commit_vld_i[0] && commit_len_i[LEN_W-1:0] == '0) |=> (flush_req_o && err_o));

    // R10: a detection leaves the retirement PC untouched.
    p_hold_on_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && any_bad) |=> $stable(retire_pc_o));

    // R3: a lone matching not-taken slot-0 commit advances by its length.
    p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && commit_vld_i == SLOTS'(1) && !commit_taken_i[0] && !any_bad)
        |=> (retire_pc_o == $past(seq_next(retire_pc_o, commit_len_i[LEN_W-1:0]))));
endmodule

// File: tb/retire_pc_checker_test.sv
// Table-driven bench for the retirement PC checker, plus directed reset tests.
module retire_pc_checker_test;
    localparam int PC_W = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic [31:0] restart_pc_i = '0;
    logic [1:0]  commit_vld_i = '0;
    logic [63:0] commit_pc_i = '0;
    logic [7:0]  commit_len_i = '0;
    logic [1:0]  commit_taken_i = '0;
    logic [63:0] commit_tgt_i = '0;
    logic        err_clr_i = 1'b0;
    logic        err_o;
    logic [0:0]  err_slot_o;
    logic [31:0] err_exp_pc_o, err_obs_pc_o, retire_pc_o;
    logic        flush_req_o;

    always #2.5 clk = ~clk;

    retire_pc_checker uut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .restart_pc_i(restart_pc_i),
        .commit_vld_i(commit_vld_i), .commit_pc_i(commit_pc_i),
        .commit_len_i(commit_len_i), .commit_taken_i(commit_taken_i),
        .commit_tgt_i(commit_tgt_i), .err_clr_i(err_clr_i), .err_o(err_o),
        .err_slot_o(err_slot_o), .err_exp_pc_o(err_exp_pc_o),
        .err_obs_pc_o(err_obs_pc_o), .flush_req_o(flush_req_o),
        .retire_pc_o(retire_pc_o)
    );

    typedef struct packed {
        logic        fl;
        logic [31:0] rpc;
        logic        v0; logic [31:0] pc0; logic [3:0] l0; logic t0; logic [31:0] g0;
        logic        v1; logic [31:0] pc1; logic [3:0] l1; logic t1; logic [31:0] g1;
        logic        clr;
        logic [31:0] e_rpc; logic e_err; logic e_slot;
        logic [31:0] e_exp; logic [31:0] e_obs; logic e_fr;
    } vec_t;

    localparam int NV = 15;
    // fl rpc | v0 pc0 l0 t0 g0 | v1 pc1 l1 t1 g1 | clr | exp: rpc err slot exp obs fr
    localparam vec_t TBL [NV] = '{
        '{0,0, 1,32'h1000,4,0,0,           0,0,0,0,0,           0, 32'h1004,0,0,0,0,0},
        '{0,0, 1,32'h1004,2,0,32'h2000,    0,0,0,0,0,           0, 32'h1006,0,0,0,0,0},
        '{0,0, 1,32'h1006,4,1,32'h2000,    0,0,0,0,0,           0, 32'h2000,0,0,0,0,0},
        '{0,0, 1,32'h2000,4,0,0,           1,32'h2004,3,0,0,    0, 32'h2007,0,0,0,0,0},
        '{0,0, 1,32'h2007,1,1,32'h3000,    1,32'h3000,4,0,0,    0, 32'h3004,0,0,0,0,0},
        '{0,0, 0,0,0,0,0,                  1,32'h3004,4,0,0,    0, 32'h3008,0,0,0,0,0},
        '{0,0, 1,32'h3010,4,0,0,           0,0,0,0,0,           0, 32'h3008,1,0,32'h3008,32'h3010,1},
        '{0,0, 0,0,0,0,0,                  0,0,0,0,0,           0, 32'h3008,1,0,32'h3008,32'h3010,0},
        '{1,32'h4000, 1,32'h9999,4,0,0,    0,0,0,0,0,           0, 32'h4000,1,0,32'h3008,32'h3010,0},
        '{0,0, 1,32'h4000,4,0,0,           1,32'h4008,4,0,0,    0, 32'h4000,1,0,32'h3008,32'h3010,1},
        '{0,0, 0,0,0,0,0,                  0,0,0,0,0,           1, 32'h4000,0,0,0,0,0},
        '{0,0, 1,32'h4000,0,0,0,           0,0,0,0,0,           0, 32'h4000,1,0,32'h4000,32'h4000,1},
        '{0,0, 1,32'h4000,4,0,0,           1,32'h4010,4,0,0,    1, 32'h4000,1,1,32'h4004,32'h4010,1},
        '{1,32'h5000, 0,0,0,0,0,           0,0,0,0,0,           1, 32'h5000,0,0,0,0,0},
        '{0,0, 1,32'h5000,15,0,0,          0,0,0,0,0,           0, 32'h500F,0,0,0,0,0}
    };
    // Requirement tags per row, for the failure messages.
    localparam string TAG [NV] = '{"R3","R3","R4","R5","R5/R4","R11","R2/R10",
        "R8/R9","R7","R9/R10","R9","R6","R9/R5","R7","R3"};

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        flush_i = 0; restart_pc_i = 0; commit_vld_i = 0; commit_pc_i = 0;
        commit_len_i = 0; commit_taken_i = 0; commit_tgt_i = 0; err_clr_i = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state after reset.
        chk("R1 retire_pc", retire_pc_o, 32'h1000);
        chk("R1 err", {31'b0, err_o}, 0);
        chk("R1 flush_req", {31'b0, flush_req_o}, 0);
        rst_n = 1;
        for (int i = 0; i < NV; i++) begin
            flush_i        = TBL[i].fl;
            restart_pc_i   = TBL[i].rpc;
            commit_vld_i   = {TBL[i].v1, TBL[i].v0};
            commit_pc_i    = {TBL[i].pc1, TBL[i].pc0};
            commit_len_i   = {TBL[i].l1, TBL[i].l0};
            commit_taken_i = {TBL[i].t1, TBL[i].t0};
            commit_tgt_i   = {TBL[i].g1, TBL[i].g0};
            err_clr_i      = TBL[i].clr;
            @(negedge clk);
            chk({TAG[i], " retire_pc"}, retire_pc_o, TBL[i].e_rpc);
            chk({TAG[i], " err"}, {31'b0, err_o}, {31'b0, TBL[i].e_err});
            chk({TAG[i], " flush_req"}, {31'b0, flush_req_o}, {31'b0, TBL[i].e_fr});
            if (TBL[i].e_err) begin
                chk({TAG[i], " err_slot"}, {31'b0, err_slot_o}, {31'b0, TBL[i].e_slot});
                chk({TAG[i], " err_exp"}, err_exp_pc_o, TBL[i].e_exp);
                chk({TAG[i], " err_obs"}, err_obs_pc_o, TBL[i].e_obs);
            end
        end
        // R1: reset while an error is held clears it and restores RESET_PC.
        idle_inputs();
        commit_vld_i = 2'b01; commit_pc_i = 64'h0; commit_len_i = 8'h04;
        @(negedge clk);
        chk("R2 err before reset", {31'b0, err_o}, 1);
        idle_inputs();
        rst_n = 0;
        @(negedge clk);
        chk("R1 retire_pc mid-run", retire_pc_o, 32'h1000);
        chk("R1 err mid-run", {31'b0, err_o}, 0);
        chk("R1 flush_req mid-run", {31'b0, flush_req_o}, 0);
        rst_n = 1;
        // R3: a not-taken commit ignores its target.
        commit_vld_i = 2'b01; commit_pc_i = {32'h0, 32'h1000};
        commit_len_i = 8'h08; commit_tgt_i = {32'h0, 32'hDEAD0000};
        @(negedge clk);
        chk("R3 target ignored", retire_pc_o, 32'h1008);
        idle_inputs();
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule